// File: doc/BRIEF.md
# Quad DAC Serial Load Interface

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host writes one channel at a time over a three-line serial link: a data line, a serial clock and a load line. Each frame is ten bits long. The first two bits pick the channel and the last eight bits carry the code. When the load line returns high, a complete frame is written into the input register of the addressed channel.

A separate active-low update input moves the contents of all four input registers into the output registers, which drive the converter codes. While update is low the outputs follow the input registers on every system clock. While it is high they hold. A mode input picks the serial protocol. Only the three-line protocol is built here. With mode low the block ignores all serial traffic. Every pin is brought into the system clock domain through two-flop synchronizers, and edges are detected after that.

A frame with the wrong number of serial clocks is thrown away and reported by a one-cycle error pulse.

Top module: `qdac_serial_if`

## Requirements
- R1: After reset, all four channel codes on `dacCode` are zero and `frameErr` is low.
- R2: With `loadIn` low, each falling edge of `serClk` takes one bit from `serData`, MSB first. The first two bits are the channel address (A1, then A0) and the next eight bits are the code (D7 down to D0).
- R3: When `loadIn` rises after exactly 10 falling edges since the previous rise, the code is written into the input register of the addressed channel. Channel n drives `dacCode[8n+7:8n]`. The other three channels keep their values.
- R4: When `loadIn` rises after fewer or more than 10 falling edges, the frame is discarded and no input register changes.
- R5: `frameErr` goes high for exactly one system clock for each discarded frame and is low at all other times.
- R6: While `updateN` is low, each output register takes the value of its input register on every system clock.
- R7: While `updateN` is high, `dacCode` holds its value. Frames received during that time change only the input registers, and these appear on the outputs once `updateN` goes low.
- R8: While `modeSel` is low (the two-wire selection), serial clocks and load edges are ignored: no input register is written and `frameErr` stays low.
- R9: With `updateN` already low, a good frame shows on `dacCode` by the fourth system clock edge after `loadIn` rises at the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock; bits are taken on its falling edge; idles high |
| serData | input | 1 | Serial data, MSB first |
| loadIn | input | 1 | Frame delimiter: low while a frame shifts in, rising edge commits |
| updateN | input | 1 | Active-low transfer of input registers to output registers |
| modeSel | input | 1 | 1 selects the three-line protocol, 0 the two-line protocol (ignored) |
| dacCode | output | 32 | Four 8-bit channel codes, channel 0 in the low byte |
| frameErr | output | 1 | One-cycle pulse when a frame has the wrong bit count |

## Verification
A pin change reaches the synchronized domain after two system clock edges. The edge detector acts in the next cycle, so an input register is written on the third edge after `loadIn` rises and the output register follows on the fourth. The bench drives all pins at the falling edge of `clk`. It holds each serial clock phase for at least two system clocks, and it compares codes and the count of error pulses exactly four edges after each load rise, which is the due cycle for R9. After each change of `updateN` or `modeSel` it waits four edges before the next comparison or frame.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  // Strobes from the frame control to the shift and register datapath
  typedef struct packed {
    logic shiftEn;  // take one serial bit this cycle
    logic commit;   // write the shifted frame into the addressed channel
  } qdacStrobe_t;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int WIDTH = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RESET_VAL;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= RESET_VAL;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int FRAME_W = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclS,
  input  logic        loadS,
  input  logic        modeS,
  output qdacStrobe_t strobe,
  output logic        frameErr
);

  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic             prevScl;
  logic             prevLoad;
  logic [CNT_W-1:0] bitCnt;
  logic             sclFall;
  logic             loadRise;
  logic             frameEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevScl  <= 1'b1;
      prevLoad <= 1'b1;
    end else begin
      prevScl  <= sclS;
      prevLoad <= loadS;
    end
  end

  assign sclFall  = prevScl & ~sclS;
  assign loadRise = ~prevLoad & loadS;
  assign frameEnd = modeS & loadRise;

  always_comb begin
    strobe.shiftEn = modeS & sclFall & ~loadS;
    strobe.commit  = frameEnd & (bitCnt == CNT_FULL);
  end

  // Bit counter saturates one past a full frame, so "too many" stays visible
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (!modeS || frameEnd) begin
      bitCnt <= '0;
    end else if (strobe.shiftEn && bitCnt != CNT_SAT) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameErr <= 1'b0;
    else       frameErr <= frameEnd & (bitCnt != CNT_FULL);
  end

  // R5: an error pulse never lasts two cycles
  a_r5_err_single: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);

  // R8: in two-wire selection no error can follow
  a_r8_mode_no_err: assert property (@(posedge clk) disable iff (!rstN)
    !modeS |=> !frameErr);

  // R2: bits are only taken while the load line is low
  a_r2_shift_load_low: assert property (@(posedge clk) disable iff (!rstN)
    loadS |-> !strobe.shiftEn);

endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int CHAN_CNT = 4,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sdaS,
  input  logic                       updNS,
  input  qdacStrobe_t                strobe,
  output logic [CHAN_CNT*DATA_W-1:0] dacCode
);

  localparam int ADDR_W  = $clog2(CHAN_CNT);
  localparam int FRAME_W = ADDR_W + DATA_W;

  logic [FRAME_W-1:0] shiftReg;
  logic [ADDR_W-1:0]  frameAddr;
  logic [DATA_W-1:0]  frameData;
  logic [DATA_W-1:0]  inReg  [CHAN_CNT];
  logic [DATA_W-1:0]  outReg [CHAN_CNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], sdaS};
  end

  assign frameAddr = shiftReg[FRAME_W-1 -: ADDR_W];
  assign frameData = shiftReg[DATA_W-1:0];

  for (genvar ch = 0; ch < CHAN_CNT; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        inReg[ch] <= '0;
      else if (strobe.commit && frameAddr == ADDR_W'(ch))
        inReg[ch] <= frameData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       outReg[ch] <= '0;
      else if (!updNS) outReg[ch] <= inReg[ch];
    end

    assign dacCode[ch*DATA_W +: DATA_W] = outReg[ch];

    // R4: no input register moves without a good frame
    a_r4_no_write_idle: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.commit |=> $stable(inReg[ch]));

    // R3: a frame for another channel leaves this one alone
    a_r3_other_chan_kept: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.commit && frameAddr != ADDR_W'(ch)) |=> $stable(inReg[ch]));

    // R7: outputs hold while update is high
    a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
      updNS |=> $stable(outReg[ch]));

    // R6: outputs track the input registers while update is low
    a_r6_track: assert property (@(posedge clk) disable iff (!rstN)
      !updNS |=> outReg[ch] == $past(inReg[ch]));
  end

endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if
  import qdac_pkg::*;
#(
  parameter int CHAN_CNT = 4,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serClk,
  input  logic                       serData,
  input  logic                       loadIn,
  input  logic                       updateN,
  input  logic                       modeSel,
  output logic [CHAN_CNT*DATA_W-1:0] dacCode,
  output logic                       frameErr
);

  localparam int ADDR_W  = $clog2(CHAN_CNT);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int PIN_W   = 5;
  // bit order {mode, update, load, data, clock}; idle-high lines reset high
  localparam logic [PIN_W-1:0] PIN_IDLE = 5'b01101;

  logic [PIN_W-1:0] pinSync;
  qdacStrobe_t      strobe;

  qdac_sync #(
    .WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)
  ) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({modeSel, updateN, loadIn, serData, serClk}),
    .syncOut(pinSync)
  );

  qdac_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclS(pinSync[0]), .loadS(pinSync[2]), .modeS(pinSync[4]),
    .strobe(strobe), .frameErr(frameErr)
  );

  qdac_datapath #(.CHAN_CNT(CHAN_CNT), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .sdaS(pinSync[1]), .updNS(pinSync[3]),
    .strobe(strobe), .dacCode(dacCode)
  );

endmodule

// File: tb/qdac_serial_if_bench.sv
module qdac_serial_if_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b1;
  logic        serData = 1'b0;
  logic        loadIn = 1'b1;
  logic        updateN = 1'b1;
  logic        modeSel = 1'b1;
  logic [31:0] dacCode;
  logic        frameErr;

  int checks = 0;
  int fails = 0;
  int errSeen = 0;
  int errExp = 0;
  bit done = 1'b0;
  logic [7:0] expIn  [4];
  logic [7:0] expOut [4];

  always #10 clk = ~clk;  // 50 MHz

  qdac_serial_if u_qdac_serial_if (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .loadIn(loadIn), .updateN(updateN), .modeSel(modeSel),
    .dacCode(dacCode), .frameErr(frameErr)
  );

  always @(negedge clk) if (rstN && frameErr) errSeen++;

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Model: outputs follow inputs while update is low
  function automatic void refreshOut();
    if (!updateN) for (int c = 0; c < 4; c++) expOut[c] = expIn[c];
  endfunction

  function automatic logic [31:0] packOut();
    return {expOut[3], expOut[2], expOut[1], expOut[0]};
  endfunction

  task automatic checkAll(input string tag);
    checkVal(tag, dacCode, packOut());
    checkVal({tag, " errcount"}, errSeen, errExp);
  endtask

  // Shift nbits bits (first 10 from {addr,data}, extras random) and raise load
  task automatic sendFrame(input logic [1:0] addr, input logic [7:0] data, input int nbits);
    logic [9:0] word = {addr, data};
    loadIn = 1'b0;
    waitEdges(3);
    for (int i = 0; i < nbits; i++) begin
      serData = (i < 10) ? word[9-i] : 1'($urandom);
      waitEdges(2);
      serClk = 1'b0;
      waitEdges(3);
      serClk = 1'b1;
      waitEdges(2);
    end
    loadIn = 1'b1;
    if (modeSel && nbits == 10) expIn[addr] = data;
    if (modeSel && nbits != 10) errExp++;
    refreshOut();
    waitEdges(4);  // R9: due by the fourth edge
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < 4; c++) begin expIn[c] = '0; expOut[c] = '0; end
    waitEdges(4);
    rstN = 1'b1;
    waitEdges(4);
    checkAll("R1 reset");

    // R7: with update high, frames reach only input registers
    sendFrame(2'd2, 8'hA5, 10);
    checkAll("R7 hold while update high");
    sendFrame(2'd0, 8'h3C, 10);
    checkAll("R7 hold second frame");
    updateN = 1'b0; refreshOut(); waitEdges(4);
    checkAll("R6 transfer on update low");

    // R3 / R2 / R9: each channel, bit order checked via distinct patterns
    sendFrame(2'd3, 8'h81, 10);
    checkAll("R9 R3 channel 3 MSB first");
    sendFrame(2'd1, 8'h01, 10);
    checkAll("R2 R3 channel 1 LSB pattern");
    sendFrame(2'd0, 8'hFF, 10);
    checkAll("R3 channel 0 all ones");

    // R4 / R5: short, empty and long frames
    sendFrame(2'd1, 8'h77, 9);
    checkAll("R4 R5 short frame");
    sendFrame(2'd2, 8'h55, 11);
    checkAll("R4 R5 long frame");
    sendFrame(2'd3, 8'h00, 0);
    checkAll("R4 R5 empty frame");

    // R8: two-wire selection ignores traffic
    modeSel = 1'b0; waitEdges(4);
    sendFrame(2'd2, 8'h12, 10);
    checkAll("R8 ignored good frame");
    sendFrame(2'd2, 8'h34, 7);
    checkAll("R8 ignored bad frame");
    modeSel = 1'b1; waitEdges(4);
    sendFrame(2'd2, 8'h9E, 10);
    checkAll("R3 after mode restore");

    // Random mix
    for (int k = 0; k < 40; k++) begin
      int pick = int'($urandom_range(0, 9));
      int nb = (pick == 0) ? 9 : (pick == 1) ? 11 : 10;
      if ($urandom_range(0, 3) == 0) begin
        updateN = ~updateN; refreshOut(); waitEdges(4);
        checkAll("R6 R7 random update toggle");
      end
      if ($urandom_range(0, 7) == 0) begin
        modeSel = ~modeSel; waitEdges(4);
      end
      sendFrame(2'($urandom), 8'($urandom), nb);
      checkAll("R3 R4 R5 R8 random frame");
    end
    modeSel = 1'b1;
    updateN = 1'b0; refreshOut(); waitEdges(4);
    checkAll("R6 final transfer");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule